// File: doc/BRIEF.md
# Serial DAC Input Word Latch

This block is the digital front end of a serial-input audio DAC. A host sends signed 20-bit samples over three wires: a data line, a bit clock, and a latch enable. Each bit enters a shift register on a rising bit-clock edge, with the most significant bit first. The host may send any number of extra bits ahead of the word, because only the newest 20 bits count.

Latch enable is sampled on each rising bit-clock edge. When a sample shows it high and the next sample shows it low, the shift register is copied into a holding register. The parallel code output then takes that value on the fourth rising edge after the low sample.

The block also checks how long latch enable stays high and low. It raises a sticky error flag when either level is held too briefly. A latch enable held low for a long time, with or without a running clock, is a single latch event.

Top module: `dac_word_latch`

## Requirements
- R1: A synchronous active-high reset clears the output code and the error flag to zero, and no latch event is pending after it.
- R2: The output code is the raw 20-bit two's complement word, passed through unchanged. The first bit received lands in bit 19 and the last bit received lands in bit 0.
- R3: Only the last 20 bits captured on edges before the latch sample are kept. Any number of earlier bits is discarded.
- R4: A latch event is a rising-edge sample of latch enable at 0 whose previous sample was 1. Holding latch enable low for any length of time starts no further event, even while bits keep arriving.
- R5: The output code holds its old value on the latch edge and on the three edges after it. It takes the latched word on the fourth rising edge after the latch edge.
- R6: If a new latch event happens while an update is still pending, the pending word is never shown. The new word is captured and its four-edge delay starts again.
- R7: If latch enable is sampled high on only one edge before a latch event, the error flag is set on the latch edge.
- R8: If latch enable goes back high on the edge right after a latch event, so that it is sampled low only once, the error flag is set on that edge.
- R9: Once set, the error flag stays at 1 until reset. A latch event that breaks a timing rule still latches and updates the output as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; every action takes place on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdata | input | 1 | Serial data bit, most significant bit first |
| le | input | 1 | Latch enable; a high-to-low change between samples triggers a latch |
| code_o | output | 20 | Parallel two's complement code driving the converter |
| err_o | output | 1 | Sticky latch-enable timing violation flag |

## Verification
The bench sends many words, each preceded by a different number of junk bits. A shift register that is too short or too long, or that is filled in the wrong order, then gives the wrong code.

For every word the bench checks the output on each of the five edges from the latch edge onward. An update that comes one edge early or one edge late is caught on that edge.

Three further cases are tested:
- Latch enable is held low for a long time while bits keep arriving. A design that treats the low level as a trigger instead of the edge would reload the code from the shift register.
- A second latch event comes while an update is pending. A design that does not restart the delay would briefly show the first word.
- Latch enable is held too briefly, once for each level. A design that misses either violation leaves the flag clear, and a design that lets the flag decay, or that skips the latch on a violation, fails on the checks made after it.

// File: rtl/dac_word_latch.sv
module dac_word_latch #(
  parameter int W        = 20,
  parameter int DELAY    = 4,
  parameter int MIN_HIGH = 2,
  parameter int MIN_LOW  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdata,
  input  logic         le,
  output logic [W-1:0] code_o,
  output logic         err_o
);
  localparam int DW = $clog2(DELAY + 1);
  localparam int HW = $clog2(MIN_HIGH + 1);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [W-1:0]  shift_q, hold_q;
  logic          le_q, pend_q, seen_fall_q;
  logic [DW-1:0] dcnt_q;
  logic [HW-1:0] hi_q;
  logic [LW-1:0] lo_q;

  wire fall     = le_q & ~le;
  wire rise     = ~le_q & le;
  wire hi_short = fall && (hi_q < HW'(MIN_HIGH));
  wire lo_short = rise && seen_fall_q && (lo_q < LW'(MIN_LOW));
  wire due      = pend_q && (dcnt_q == DW'(DELAY));

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q     <= '0;
      hold_q      <= '0;
      code_o      <= '0;
      le_q        <= 1'b0;
      pend_q      <= 1'b0;
      seen_fall_q <= 1'b0;
      dcnt_q      <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      err_o       <= 1'b0;
    end else begin
      shift_q <= {shift_q[W-2:0], sdata};
      le_q    <= le;

      if (rise) hi_q <= HW'(1);
      else if (le && hi_q != HW'(MIN_HIGH)) hi_q <= hi_q + HW'(1);

      if (fall) lo_q <= LW'(1);
      else if (!le && lo_q != LW'(MIN_LOW)) lo_q <= lo_q + LW'(1);

      if (fall) seen_fall_q <= 1'b1;

      if (fall) begin
        hold_q <= shift_q;
        pend_q <= 1'b1;
        dcnt_q <= DW'(1);
      end else if (due) begin
        code_o <= hold_q;
        pend_q <= 1'b0;
      end else if (pend_q) begin
        dcnt_q <= dcnt_q + DW'(1);
      end

      if (hi_short || lo_short) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_word_latch_chk.sv
module dac_word_latch_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         le,
  input logic [W-1:0] code_o,
  input logic         err_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (code_o == '0) && !err_o);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  a_r5_update_timing: assert property (@(posedge clk) disable iff (rst)
    (!$stable(code_o) && !$past(rst)) |-> (!$past(le, 5) && $past(le, 6)));

  a_r8_short_low: assert property (@(posedge clk) disable iff (rst)
    ($past(le, 2) && !$past(le) && le && !$past(rst) && !$past(rst, 2)) |=> err_o);

  a_r7_short_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(le, 2) && $past(le) && !le && !$past(rst) && !$past(rst, 2)) |=> err_o);
endmodule

bind dac_word_latch dac_word_latch_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .le(le), .code_o(code_o), .err_o(err_o)
);

// File: tb/dac_word_latch_tb.sv
`timescale 1ns/1ps
module dac_word_latch_tb;
  localparam int W = 20;
  logic clk = 0, rst = 1, sdata = 0, le = 1;
  logic [W-1:0] code;
  logic err;
  int checks = 0, fails = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [W-1:0] cur = '0;

  always #2.5 clk = ~clk;

  dac_word_latch u_dut (.clk(clk), .rst(rst), .sdata(sdata), .le(le), .code_o(code), .err_o(err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic nextbit();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31];
  endfunction

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      sdata = w[i];
      tick();
    end
  endtask

  // R2 R3 R5: leading junk, word, fall, five-edge timing check
  task automatic frame(input int lead, input logic [W-1:0] w);
    le = 1;
    tick(); tick();
    for (int i = 0; i < lead; i++) begin sdata = nextbit(); tick(); end
    shift_word(w);
    le = 0;
    for (int k = 0; k < 4; k++) begin
      sdata = nextbit();
      tick();
      chk("R5 hold before 4th edge", 32'(code), 32'(cur));
    end
    tick();
    chk("R2 R3 R5 word after 4th edge", 32'(code), 32'(w));
    cur = w;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, w1, exp;
    logic [3:0] x;
    logic xb;
    tick(); tick();
    rst = 0;
    chk("R1 code reset", 32'(code), 0);
    chk("R1 err reset", 32'(err), 0);

    for (int i = 0; i < 36; i++) begin
      logic [W-1:0] w;
      case (i)
        0: w = 20'h00001;
        1: w = 20'hFFFFF;
        2: w = 20'h80000;
        3: w = 20'h7FFFF;
        4: w = 20'h00000;
        default: w = (i < 25) ? (W'(1) << (i - 5)) : W'(lcg[29:10] ^ 20'h5A5A5);
      endcase
      if (i >= 25) void'(nextbit());
      frame(i % 7, w);
    end
    chk("R9 no error in clean frames", 32'(err), 0);

    // R4: long low with running clock
    for (int i = 0; i < 40; i++) begin
      sdata = nextbit();
      tick();
      if (i % 8 == 7) chk("R4 long low no new latch", 32'(code), 32'(cur));
    end

    // R6: restart while pending
    a = 20'hA5C3E;
    le = 1; tick(); tick();
    shift_word(a);
    le = 0; x = 4'b1011;
    sdata = x[3]; tick();
    chk("R6 old kept", 32'(code), 32'(cur));
    sdata = x[2]; tick();
    le = 1;
    sdata = x[1]; tick();
    sdata = x[0]; tick();
    le = 0;
    b = {a[15:0], x};
    for (int k = 0; k < 4; k++) begin
      sdata = nextbit();
      tick();
      chk("R6 pending word discarded", 32'(code), 32'(cur));
    end
    tick();
    chk("R6 newer word shown", 32'(code), 32'(b));
    cur = b;
    chk("R6 no error", 32'(err), 0);

    // R8: low sampled once
    tick();
    le = 1; tick(); tick();
    le = 0; tick();
    le = 1; tick();
    chk("R8 short low flagged", 32'(err), 1);
    for (int i = 0; i < 10; i++) tick();
    chk("R9 err sticky", 32'(err), 1);
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 err cleared", 32'(err), 0);
    chk("R1 code cleared", 32'(code), 0);
    cur = '0;

    // R7: high sampled once; R9 latch still proceeds
    le = 0;
    w1 = 20'h3C5F1;
    shift_word(w1);
    xb = 1'b1;
    le = 1; sdata = xb; tick();
    le = 0; sdata = 0; tick();
    chk("R7 short high flagged", 32'(err), 1);
    exp = {w1[W-2:0], xb};
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 hold after flagged latch", 32'(code), 0);
    end
    tick();
    chk("R9 flagged latch still updates", 32'(code), 32'(exp));
    chk("R9 err still set", 32'(err), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule